// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps one small table of radio calibration words for each receive chain and can replay the stored words into the radio on command. Every table has six slots of 28 bits each. Slots 0 to 2 hold the three DC-offset DAC settings (loop, low and high). Slot 3 holds the filter cutoff, slot 4 the receive gain setting, and slot 5 the peak-detector offset. The controller does not interpret these values.

Software reaches a table indirectly, through a command register and a data register for each chain. It writes the slot index and the direction into the command register with the go bit clear, and then sets the go bit. The hardware performs the transfer and clears the go bit when it is done. A control register holds a global enable, a per-slot replay mask and a self-clearing replay trigger. When the trigger is set, a sequencer scans every chain and every slot in ascending order. It sends each masked slot on a radio-side valid/ready port and keeps the trigger bit at 1 until the scan is complete.

Top module: `cal_retain_ctrl`

## Requirements
- R1: Each chain has its own table of 6 entries of 28 bits. The data register of a chain carries the word in bits [27:0] and reads 0 in the bits above.
- R2: Register map: address 0 is control, address 1+2c is the command register of chain c, and address 2+2c is the data register of chain c. The command register has the slot index in bits [2:0], the write-select in bit 4 and the go bit in bit 8. The go bit reads 1 while a transfer is pending and returns to 0 once the transfer has completed.
- R3: A transfer with write-select at 1 copies the chain's data register into the addressed slot.
- R4: A transfer with write-select at 0 loads the addressed slot into the data register, which is readable once the go bit is 0.
- R5: A transfer to slot 6 or 7 completes and clears the go bit. A write to such a slot changes no entry, and a read of it sets the data register to 0.
- R6: The control register has the enable in bit 0, the replay mask in bits [13:8] (bit 8+e for slot e) and the replay trigger in bit 16.
- R7: The trigger bit reads 1 for the whole replay and clears after the scan has passed the last slot of the last chain.
- R8: A replay sends exactly the slots whose mask bit is 1. It goes through the chains in ascending order and, within a chain, through the slots in ascending index order. Each word is sent with its chain number and slot index.
- R9: While the radio holds ready low, rad_valid stays high and chain, index and data stay unchanged.
- R10: The trigger is accepted only from a control write that also sets the enable bit. A go bit written while the enable is 0 is dropped, and no transfer takes place.
- R11: A transfer requested during a replay stays pending until the replay ends, and then completes. Control writes during a replay are ignored.
- R12: After reset all table entries, the control register, the command registers and the data registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rad_valid | output | 1 | Replay word valid |
| rad_chain | output | CW | Chain number of the replay word |
| rad_idx | output | IW | Slot index of the replay word |
| rad_data | output | DW | Replayed calibration word |
| rad_ready | input | 1 | Radio accepts the replay word |

## Verification
Table transfers use random chains, slots and 28-bit words, and every slot is read back afterwards. This separates correct slot and chain addressing from aliasing between slots or chains. Replays run with an empty mask, a full mask and random masks, under random ready stalls and under a permanent stall. The empty and full masks separate correct mask filtering and ordering from entries that are dropped or duplicated, and the stalls show whether a held word stays intact. Directed cases cover slots 6 and 7, a request and a trigger written with the enable low, and a transfer and a control write issued while a replay is stalled.

// File: rtl/cal_retain_ctrl.sv
module cal_retain_ctrl #(
  parameter int NCHAIN = 3,
  parameter int NENT   = 6,
  parameter int DW     = 28,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rad_valid,
  output logic [(NCHAIN>1?$clog2(NCHAIN):1)-1:0] rad_chain,
  output logic [2:0]    rad_idx,
  output logic [DW-1:0] rad_data,
  input  logic          rad_ready
);
  localparam int CW = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;
  localparam int IW = 3;

  logic            en, force_r;
  logic [NENT-1:0] mask;
  logic [IW-1:0]   cmd_idx [NCHAIN];
  logic            cmd_wr  [NCHAIN];
  logic [NCHAIN-1:0] acc;
  logic [DW-1:0]   dat [NCHAIN];
  logic [DW-1:0]   tbl [NCHAIN][NENT];
  logic [CW-1:0]   sc;
  logic [IW-1:0]   si;

  wire last = (sc == CW'(NCHAIN-1)) && (si == IW'(NENT-1));
  wire step = force_r && (!rad_valid || rad_ready);

  assign rad_valid = force_r && mask[si];
  assign rad_chain = sc;
  assign rad_idx   = si;
  assign rad_data  = tbl[sc][si];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[0]        = en;
      reg_rdata[8 +: NENT] = mask;
      reg_rdata[16]       = force_r;
    end
    for (int c = 0; c < NCHAIN; c++) begin
      if (reg_addr == AW'(1 + 2*c))
        reg_rdata = {23'b0, acc[c], 3'b0, cmd_wr[c], 1'b0, cmd_idx[c]};
      if (reg_addr == AW'(2 + 2*c))
        reg_rdata = {{(32-DW){1'b0}}, dat[c]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; force_r <= 1'b0; mask <= '0;
      sc <= '0; si <= '0; acc <= '0;
      for (int c = 0; c < NCHAIN; c++) begin
        cmd_idx[c] <= '0; cmd_wr[c] <= 1'b0; dat[c] <= '0;
        for (int e = 0; e < NENT; e++) tbl[c][e] <= '0;
      end
    end else begin
      if (step) begin
        if (last) begin
          force_r <= 1'b0; sc <= '0; si <= '0;
        end else if (si == IW'(NENT-1)) begin
          si <= '0; sc <= sc + 1'b1;
        end else begin
          si <= si + 1'b1;
        end
      end
      for (int c = 0; c < NCHAIN; c++) begin
        if (acc[c] && !force_r) begin
          acc[c] <= 1'b0;
          if (cmd_idx[c] < IW'(NENT)) begin
            if (cmd_wr[c]) tbl[c][cmd_idx[c]] <= dat[c];
            else           dat[c] <= tbl[c][cmd_idx[c]];
          end else if (!cmd_wr[c]) begin
            dat[c] <= '0;
          end
        end
        if (reg_we && reg_addr == AW'(1 + 2*c)) begin
          cmd_idx[c] <= reg_wdata[2:0];
          cmd_wr[c]  <= reg_wdata[4];
          acc[c]     <= reg_wdata[8] & en;
        end
        if (reg_we && reg_addr == AW'(2 + 2*c))
          dat[c] <= reg_wdata[DW-1:0];
      end
      if (reg_we && reg_addr == '0 && !force_r) begin
        en      <= reg_wdata[0];
        mask    <= reg_wdata[8 +: NENT];
        force_r <= reg_wdata[16] & reg_wdata[0];
      end
    end
  end
endmodule

module cal_retain_chk #(
  parameter int NCHAIN = 3,
  parameter int NENT   = 6,
  parameter int DW     = 28,
  parameter int CW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              en,
  input logic              force_r,
  input logic [NCHAIN-1:0] acc,
  input logic              rad_valid,
  input logic              rad_ready,
  input logic [CW-1:0]     rad_chain,
  input logic [2:0]        rad_idx,
  input logic [DW-1:0]     rad_data
);
  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rad_valid && !rad_ready |=> rad_valid && $stable(rad_data) && $stable(rad_idx) && $stable(rad_chain));
  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rad_valid |-> (rad_idx < 3'(NENT)) && (rad_chain < CW'(NCHAIN)));
  // R7
  trig_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_r) |-> $past(rad_chain == CW'(NCHAIN-1) && rad_idx == 3'(NENT-1)));
  // R11
  acc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_r && !reg_we |=> ((~acc & $past(acc)) == '0));
  // R10
  trig_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_r |-> en);
endmodule

bind cal_retain_ctrl cal_retain_chk #(.NCHAIN(NCHAIN), .NENT(NENT), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .en(en), .force_r(force_r), .acc(acc),
  .rad_valid(rad_valid), .rad_ready(rad_ready), .rad_chain(rad_chain),
  .rad_idx(rad_idx), .rad_data(rad_data));

// File: tb/cal_retain_ctrl_tb.sv
`timescale 1ns/1ps
module cal_retain_ctrl_tb;
  localparam int NCHAIN = 3, NENT = 6, DW = 28, AW = 4;
  logic clk = 0, rst_n = 0, reg_we = 0, rad_ready = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rad_valid;
  logic [1:0] rad_chain;
  logic [2:0] rad_idx;
  logic [DW-1:0] rad_data;

  int checks = 0, fails = 0, rmode = 0, nlog = 0;
  logic [DW-1:0] exp_t [NCHAIN][NENT];
  logic [31:0] log_w [64];

  cal_retain_ctrl #(.NCHAIN(NCHAIN), .NENT(NENT), .DW(DW), .AW(AW)) u_dut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    logic nr;
    nr = (rmode == 0) ? 1'($urandom) : (rmode == 2);
    if (rad_valid && nr && nlog < 64) begin
      log_w[nlog] = {2'b0, rad_chain, rad_idx[1:0] == rad_idx[1:0] ? rad_idx : 3'd0, 1'b0, rad_data[23:0]};
      if (rad_data != exp_t[rad_chain][rad_idx]) begin
        fails++; $display("FAIL R8 replay data c%0d e%0d act=%h exp=%h", rad_chain, rad_idx, rad_data, exp_t[rad_chain][rad_idx]);
      end
      nlog++;
    end
    rad_ready = nr;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, expv); end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a); #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cmdw(int e, bit w, bit go);
    return {23'b0, go, 3'b0, w, 1'b0, 3'(e)};
  endfunction

  task automatic wait_go(int c);
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin rd(1+2*c, v); if (!v[8]) break; end
  endtask

  task automatic sw_write(int c, int e, logic [DW-1:0] d);
    wr(2+2*c, {4'b0, d}); wr(1+2*c, cmdw(e,1,0)); wr(1+2*c, cmdw(e,1,1)); wait_go(c);
    if (e < NENT) exp_t[c][e] = d;
  endtask

  task automatic sw_read(int c, int e, output logic [31:0] d);
    wr(1+2*c, cmdw(e,0,0)); wr(1+2*c, cmdw(e,0,1)); wait_go(c); rd(2+2*c, d);
  endtask

  function automatic int exp_count(logic [NENT-1:0] m);
    return NCHAIN * $countones(m);
  endfunction

  task automatic replay(logic [NENT-1:0] m, int mode);
    logic [31:0] v;
    nlog = 0; rmode = mode;
    wr(0, {15'b0, 1'b1, 2'b0, m, 7'b0, 1'b1});
    for (int k = 0; k < 2000; k++) begin rd(0, v); if (!v[16]) break; end
    chk("R7 trigger cleared after replay", {31'b0, v[16]}, 0);
    chk("R8 replay word count", nlog, exp_count(m));
    begin
      int n = 0;
      for (int c = 0; c < NCHAIN; c++)
        for (int e = 0; e < NENT; e++)
          if (m[e]) begin
            if (n < nlog) chk("R8 replay order", {log_w[n][29:28], log_w[n][27:25]}, {3'(c), 3'(e)} & 5'h1f);
            n++;
          end
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++; $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    for (int c = 0; c < NCHAIN; c++) for (int e = 0; e < NENT; e++) exp_t[c][e] = '0;
    repeat (3) @(negedge clk); rst_n = 1;

    rd(0, v); chk("R12 control reset", v, 0);
    rd(1, v); chk("R12 command reset", v, 0);
    rd(2, v); chk("R12 data reset", v, 0);

    // R10: go bit and trigger with enable low
    wr(4, 32'h0ABCDEF); wr(3, cmdw(1,1,1)); rd(3, v);
    chk("R10 go dropped while disabled", {31'b0, v[8]}, 0);
    nlog = 0; rmode = 2;
    wr(0, 32'h0001_3F00); repeat (4) @(negedge clk); rd(0, v);
    chk("R10 trigger ignored without enable", {31'b0, v[16]}, 0);
    chk("R10 no replay words", nlog, 0);

    wr(0, 32'h1);
    sw_read(1, 1, v); chk("R10 R12 entry untouched", v, 0);

    // R3 R4 R1 random transfers
    for (int k = 0; k < 40; k++) begin
      int c = $urandom % NCHAIN, e = $urandom % NENT;
      sw_write(c, e, DW'($urandom));
    end
    sw_write(2, 5, 28'hFFFFFFF);
    for (int c = 0; c < NCHAIN; c++)
      for (int e = 0; e < NENT; e++) begin
        sw_read(c, e, v); chk("R3 R4 R1 readback", v, {4'b0, exp_t[c][e]});
      end
    rd(5, v); chk("R2 command fields", v, cmdw(5,0,0));

    // R5 out-of-range slots
    sw_write(0, 6, 28'h1234567); sw_write(0, 7, 28'h7654321);
    rd(1, v); chk("R5 go cleared on slot 7", {31'b0, v[8]}, 0);
    for (int e = 0; e < NENT; e++) begin sw_read(0, e, v); chk("R5 write to 6/7 no effect", v, {4'b0, exp_t[0][e]}); end
    wr(2, 32'h0FFFFFFF); sw_read(0, 6, v); chk("R5 read of slot 6 is zero", v, 0);

    // R6 control layout
    wr(0, 32'h0000_2A01); rd(0, v); chk("R6 control readback", v, 32'h0000_2A01);

    // R7 R8 R9 replays
    replay(6'h00, 0);
    replay(6'h3F, 0);
    replay(6'h10, 2);
    for (int k = 0; k < 4; k++) replay(NENT'($urandom), 0);

    // R11 transfer and control write during a stalled replay
    nlog = 0; rmode = 1;
    wr(0, 32'h0001_3F01);
    wr(1, cmdw(2,0,0)); wr(1, cmdw(2,0,1));
    repeat (5) @(negedge clk);
    rd(1, v); chk("R11 go held during replay", {31'b0, v[8]}, 1);
    wr(0, 32'h0000_0001); rd(0, v); chk("R11 control write ignored", v, 32'h0001_3F01);
    chk("R9 nothing accepted while stalled", nlog, 0);
    rmode = 2;
    for (int k = 0; k < 200; k++) begin rd(0, v); if (!v[16]) break; end
    chk("R8 full replay after stall", nlog, NCHAIN*NENT);
    wait_go(0); rd(2, v); chk("R11 held read completes", v, {4'b0, exp_t[0][2]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule